// File: doc/BRIEF.md
# Password-Guarded Pin Lock Register

This block write-protects the configuration of one bank of general-purpose pins. It keeps a lock bitmap with one bit per pin, where a set bit means the pin is locked. It turns that bitmap into a per-pin write-allow mask and into gated per-pin write strobes for the pin control registers that sit next to it. Software changes the bitmap in two steps. First it writes a magic key to a dedicated key register, which arms the block. The very next bus write, if it targets the lock register, loads the bitmap. Any other write in between cancels the arming. Reads do not count as writes.

The arming logic is a two-state machine. `ARM_IDLE` is the disarmed state. `ARM_READY` means armed, waiting for the lock write. The transitions are:

- **arm**: `ARM_IDLE` to `ARM_READY` on a correct key write.
- **commit**: `ARM_READY` to `ARM_IDLE` on a lock register write, which loads the bitmap.
- **rearm**: `ARM_READY` to `ARM_READY` on another correct key write.
- **cancel**: `ARM_READY` to `ARM_IDLE` on any other write, including a wrong key.

Idle cycles and reads leave the state unchanged in both states.

Software updates single bits by read-modify-write. It reads the bitmap, changes one bit, writes the key, then writes the new bitmap back. Bitmap updates keep the plain load-the-written-value semantics. Software normally issues an all-ones value to lock the whole bank and all zeros to unlock it.

Top module: `pin_lock_guard`

## Requirements
- R1: After reset every pin is locked: the bitmap reads all ones, `pin_wr_allow` is all zeros, and the block is disarmed.
- R2: A bus write of key 0x00A5A501 to address 0x520 arms the block. If the next bus write targets the lock address 0x500 + 4*BANK_ID, its low PINS data bits replace the bitmap, and the new value is visible from the following cycle. All-ones and all-zeros values load like any other value.
- R3: A write to the lock address while disarmed leaves the bitmap unchanged.
- R4: A write to address 0x520 with any value other than 0x00A5A501 does not arm the block and disarms an armed block. The bitmap is unchanged.
- R5: While armed, a write to any address other than 0x520 or the lock address disarms the block without changing the bitmap. Pin control writes count as such writes. Idle cycles and reads do not disarm.
- R6: Each arming allows exactly one bitmap load. A second lock write without a new key write is ignored.
- R7: Reading the lock address via `rd_addr` returns the bitmap in bits [PINS-1:0] with zero above, combinationally and at any time. Every other read address returns zero.
- R8: `pin_wr_allow[i]` is 1 exactly when bitmap bit i is 0, meaning the pin is unlocked.
- R9: A bus write to control address 0x100 + 4*(BANK_ID*PINS + i) raises `pin_cfg_we[i]` in the same cycle only when pin i is unlocked. A write to a locked pin raises no strobe, so its control register keeps its contents. At most one strobe is high.
- R10: A correct key write while already armed keeps the block armed for the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Bus write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte address of the write |
| bus_wdata | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data, combinational |
| pin_wr_allow | output | PINS | Per-pin write-enable mask, 1 = unlocked |
| pin_cfg_we | output | PINS | Gated write strobes for the pin control registers |

## Verification
The hardest situation to reach is an armed block that meets a write which is neither the key nor the lock register. Examples are a pin control write that itself raises a strobe, a write to an unrelated address, or a wrong key. Each of these must cancel the arming silently. The bench reaches this state by issuing the key write, then the interfering write, then a lock write whose data would visibly change the bitmap. Reading back an unchanged bitmap proves the cancel. A matching sequence with only reads and idle cycles between the key and the lock write proves that those do not disarm.

// File: rtl/plg_pkg.sv
package plg_pkg;

    // Address map of one bank (byte offsets)
    localparam int unsigned KEY_OFFSET       = 32'h520;
    localparam int unsigned LOCK_BASE_OFFSET = 32'h500;
    localparam int unsigned CTRL_BASE_OFFSET = 32'h100;

    // Key value that arms a bitmap update
    localparam logic [31:0] ARM_KEY = 32'h00A5_A501;

    typedef enum logic [0:0] {
        ARM_IDLE  = 1'b0,
        ARM_READY = 1'b1
    } arm_state_e;

endpackage

// File: rtl/plg_addr_decode.sv
module plg_addr_decode
    import plg_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int PINS    = 32,
    parameter int BANK_ID = 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              hit_key,
    output logic              key_ok,
    output logic              hit_lock,
    output logic [PINS-1:0]   ctrl_sel
);

    localparam logic [ADDR_W-1:0] KEY_ADDR  = ADDR_W'(KEY_OFFSET);
    localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(LOCK_BASE_OFFSET + 4 * BANK_ID);
    localparam int                PIN_BASE  = BANK_ID * PINS;

    always_comb begin
        hit_key  = (addr == KEY_ADDR);
        hit_lock = (addr == LOCK_ADDR);
        key_ok   = (wdata == DATA_W'(ARM_KEY));
    end

    for (genvar g = 0; g < PINS; g++) begin : g_ctrl
        localparam logic [ADDR_W-1:0] PIN_ADDR =
            ADDR_W'(CTRL_BASE_OFFSET + 4 * (PIN_BASE + g));
        assign ctrl_sel[g] = (addr == PIN_ADDR);
    end

endmodule

// File: rtl/plg_arm_fsm.sv
module plg_arm_fsm
    import plg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic hit_key,
    input  logic key_ok,
    input  logic hit_lock,
    output logic armed,
    output logic commit
);

    arm_state_e state_q;
    arm_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARM_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: arm, commit, rearm, cancel
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARM_IDLE: begin
                if (wr && hit_key && key_ok) begin
                    state_d = ARM_READY;
                end
            end
            ARM_READY: begin
                if (wr) begin
                    if (hit_key && key_ok) begin
                        state_d = ARM_READY;
                    end else begin
                        state_d = ARM_IDLE;
                    end
                end
            end
            default: state_d = ARM_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        armed  = 1'b0;
        commit = 1'b0;
        unique case (state_q)
            ARM_IDLE: begin
                armed = 1'b0;
            end
            ARM_READY: begin
                armed  = 1'b1;
                commit = wr && hit_lock;
            end
            default: begin
                armed = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/plg_lock_store.sv
module plg_lock_store
    import plg_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int PINS    = 32,
    parameter int BANK_ID = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [PINS-1:0]   new_bits,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [PINS-1:0]   lock_q
);

    localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(LOCK_BASE_OFFSET + 4 * BANK_ID);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= '1;
        end else if (commit) begin
            lock_q <= new_bits;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == LOCK_ADDR) begin
            rd_data[PINS-1:0] = lock_q;
        end
    end

endmodule

// File: rtl/plg_write_gate.sv
module plg_write_gate #(
    parameter int PINS = 32
) (
    input  logic            wr,
    input  logic [PINS-1:0] ctrl_sel,
    input  logic [PINS-1:0] lock_q,
    output logic [PINS-1:0] allow,
    output logic [PINS-1:0] cfg_we
);

    for (genvar g = 0; g < PINS; g++) begin : g_pin
        assign allow[g]  = ~lock_q[g];
        assign cfg_we[g] = wr & ctrl_sel[g] & ~lock_q[g];
    end

endmodule

// File: rtl/pin_lock_guard.sv
module pin_lock_guard
    import plg_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int PINS    = 32,
    parameter int BANK_ID = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [PINS-1:0]   pin_wr_allow,
    output logic [PINS-1:0]   pin_cfg_we
);

    logic            hit_key;
    logic            key_ok;
    logic            hit_lock;
    logic [PINS-1:0] ctrl_sel;
    logic            armed;
    logic            commit;
    logic [PINS-1:0] lock_q;

    plg_addr_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PINS   (PINS),
        .BANK_ID(BANK_ID)
    ) u_dec (
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .hit_key (hit_key),
        .key_ok  (key_ok),
        .hit_lock(hit_lock),
        .ctrl_sel(ctrl_sel)
    );

    plg_arm_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (bus_wr),
        .hit_key (hit_key),
        .key_ok  (key_ok),
        .hit_lock(hit_lock),
        .armed   (armed),
        .commit  (commit)
    );

    plg_lock_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PINS   (PINS),
        .BANK_ID(BANK_ID)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .new_bits(bus_wdata[PINS-1:0]),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .lock_q  (lock_q)
    );

    plg_write_gate #(
        .PINS(PINS)
    ) u_gate (
        .wr      (bus_wr),
        .ctrl_sel(ctrl_sel),
        .lock_q  (lock_q),
        .allow   (pin_wr_allow),
        .cfg_we  (pin_cfg_we)
    );

endmodule

// File: rtl/pin_lock_guard_chk.sv
module pin_lock_guard_chk
    import plg_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int PINS    = 32,
    parameter int BANK_ID = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              armed,
    input logic              commit,
    input logic [PINS-1:0]   lock_q,
    input logic [PINS-1:0]   pin_cfg_we
);

    localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(KEY_OFFSET);

    // R1: reset locks everything and disarms
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (&lock_q) && !armed);

    // R2: correct key arms
    assert_key_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == KEY_A && bus_wdata == DATA_W'(ARM_KEY) |=> armed);

    // R2: a commit loads the written bits
    assert_commit_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> lock_q == $past(bus_wdata[PINS-1:0]));

    // R3: bitmap changes only after a commit
    assert_lock_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q != $past(lock_q) |-> $past(commit));

    // R4: wrong key leaves the block disarmed
    assert_bad_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == KEY_A && bus_wdata != DATA_W'(ARM_KEY) |=> !armed);

    // R5 / R6: any non-key write while armed disarms
    assert_other_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        armed && bus_wr && bus_addr != KEY_A |=> !armed);

    // R9: no strobe for a locked pin
    assert_gate_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cfg_we & lock_q) == '0);

    // R9: at most one strobe
    assert_strobe_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pin_cfg_we));

endmodule

bind pin_lock_guard pin_lock_guard_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PINS   (PINS),
    .BANK_ID(BANK_ID)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .armed     (armed),
    .commit    (commit),
    .lock_q    (lock_q),
    .pin_cfg_we(pin_cfg_we)
);

// File: tb/pin_lock_guard_tb.sv
`timescale 1ns/1ps
module pin_lock_guard_tb;

    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int PINS    = 32;
    localparam int BANK_ID = 1;

    localparam logic [ADDR_W-1:0] KEY_A  = 12'h520;
    localparam logic [ADDR_W-1:0] LOCK_A = 12'h504;
    localparam logic [31:0]       KEY_V  = 32'h00A5_A501;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic [PINS-1:0]   pin_wr_allow;
    logic [PINS-1:0]   pin_cfg_we;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    pin_lock_guard #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PINS(PINS), .BANK_ID(BANK_ID)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
        .pin_wr_allow(pin_wr_allow), .pin_cfg_we(pin_cfg_we)
    );

    function automatic logic [ADDR_W-1:0] ctrl_addr(input int pin);
        return ADDR_W'(12'h100 + 4 * (BANK_ID * PINS + pin));
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    // Control write, sampling the strobes while the write is presented
    task automatic ctrl_probe(input int pin, input logic [31:0] exp_we, input string req);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = ctrl_addr(pin); bus_wdata = 32'h5A;
        #1;
        check(pin_cfg_we == exp_we, req, pin_cfg_we, exp_we);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic read_lock(output logic [31:0] v);
        @(negedge clk);
        rd_addr = LOCK_A;
        #1;
        v = rd_data;
    endtask

    task automatic expect_lock(input logic [31:0] exp, input string req);
        logic [31:0] v;
        read_lock(v);
        check(v == exp, req, v, exp);
    endtask

    task automatic t_reset;
        expect_lock(32'hFFFF_FFFF, "R1 reset bitmap");
        check(pin_wr_allow == '0, "R1 reset allow", pin_wr_allow, 32'h0);
        ctrl_probe(3, 32'h0, "R9 locked pin after reset");
        // Lock write right after reset must not load (disarmed)
        bus_write(LOCK_A, 32'h0);
        expect_lock(32'hFFFF_FFFF, "R1 disarmed after reset");
    endtask

    task automatic t_no_key;
        bus_write(LOCK_A, 32'h0000_1234);
        expect_lock(32'hFFFF_FFFF, "R3 lock write without key");
    endtask

    task automatic t_unlock_some;
        bus_write(KEY_A, KEY_V);
        bus_write(LOCK_A, 32'hFFFF_FF0F);
        expect_lock(32'hFFFF_FF0F, "R2 bitmap load");
        check(pin_wr_allow == 32'h0000_00F0, "R8 allow mask", pin_wr_allow, 32'h0000_00F0);
        ctrl_probe(5, 32'h0000_0020, "R9 unlocked pin strobe");
        ctrl_probe(9, 32'h0, "R9 locked pin no strobe");
    endtask

    task automatic t_single_use;
        bus_write(KEY_A, KEY_V);
        bus_write(LOCK_A, 32'h0000_0000);
        expect_lock(32'h0, "R2 all zeros unlocks");
        bus_write(LOCK_A, 32'hFFFF_FFFF);
        expect_lock(32'h0, "R6 second lock write ignored");
        bus_write(KEY_A, KEY_V);
        bus_write(LOCK_A, 32'hFFFF_FFFF);
        expect_lock(32'hFFFF_FFFF, "R2 all ones locks");
    endtask

    task automatic t_wrong_key;
        bus_write(KEY_A, 32'h00A5_A500);
        bus_write(LOCK_A, 32'h0);
        expect_lock(32'hFFFF_FFFF, "R4 wrong key does not arm");
        bus_write(KEY_A, KEY_V);
        bus_write(KEY_A, 32'hA5A5_0100);
        bus_write(LOCK_A, 32'h0);
        expect_lock(32'hFFFF_FFFF, "R4 wrong key disarms");
    endtask

    task automatic t_intervene;
        // First unlock pin 5 so the intervening control write strobes
        bus_write(KEY_A, KEY_V);
        bus_write(LOCK_A, 32'hFFFF_FFDF);
        expect_lock(32'hFFFF_FFDF, "R2 unlock pin 5");
        bus_write(KEY_A, KEY_V);
        ctrl_probe(5, 32'h0000_0020, "R9 strobe while armed");
        bus_write(LOCK_A, 32'h0);
        expect_lock(32'hFFFF_FFDF, "R5 control write disarms");
        bus_write(KEY_A, KEY_V);
        bus_write(12'h000, 32'h1);
        bus_write(LOCK_A, 32'h0);
        expect_lock(32'hFFFF_FFDF, "R5 unrelated write disarms");
        // Reads and idle cycles keep the arming
        bus_write(KEY_A, KEY_V);
        expect_lock(32'hFFFF_FFDF, "R7 read while armed");
        repeat (4) @(negedge clk);
        bus_write(LOCK_A, 32'h1234_5678);
        expect_lock(32'h1234_5678, "R5 reads and idle keep arming");
    endtask

    task automatic t_rearm;
        bus_write(KEY_A, KEY_V);
        bus_write(KEY_A, KEY_V);
        bus_write(LOCK_A, 32'hAAAA_5555);
        expect_lock(32'hAAAA_5555, "R10 rearm keeps arming");
        check(pin_wr_allow == 32'h5555_AAAA, "R8 allow after rearm", pin_wr_allow, 32'h5555_AAAA);
    endtask

    task automatic t_read_map;
        logic [31:0] v;
        @(negedge clk);
        rd_addr = KEY_A;
        #1;
        check(rd_data == 32'h0, "R7 other address reads zero", rd_data, 32'h0);
        rd_addr = 12'h500;
        #1;
        check(rd_data == 32'h0, "R7 other bank lock reads zero", rd_data, 32'h0);
        // Read-modify-write of one bit
        read_lock(v);
        v[0] = 1'b0;
        bus_write(KEY_A, KEY_V);
        bus_write(LOCK_A, v);
        expect_lock(32'hAAAA_5554, "R2 read-modify-write one bit");
        ctrl_probe(0, 32'h0000_0001, "R9 pin 0 now writable");
        ctrl_probe(31, 32'h0, "R9 pin 31 still locked");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_no_key();
        t_unlock_some();
        t_single_use();
        t_wrong_key();
        t_intervene();
        t_rearm();
        t_read_map();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule